// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block sits on the master side of a pipelined system bus. When a burst is requested, it captures the start address, the burst type and the transfer size. It then drives the address and transfer type of each beat on the address phase. A beat counts as taken on every clock edge where the bus ready input is high. The address moves to the next beat only at such an edge, so wait states hold the current beat unchanged on the bus.

The block supports single transfers, fixed-length incrementing bursts of 4, 8 or 16 beats, wrapping bursts of 4, 8 or 16 beats, and incrementing bursts of undefined length. An undefined-length burst runs until the stop input asks for an end, or until its next beat would cross a 1 KB boundary. A fixed-length incrementing request that would cross a 1 KB boundary is refused, and so is a transfer size wider than the data bus. A refused request raises an error pulse and issues no transfer. A one-cycle done pulse marks the cycle in which the bus returns to idle after the last beat.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (rst_n low, sampled on the clock) is active and after it, htrans is IDLE (2'b00), and done and err are 0, until a request is accepted.
- R2: A start sampled high while idle and not refused makes the next cycle's outputs htrans = NONSEQ (2'b10) and haddr = addr, with hburst and hsize equal to the requested burst and size.
- R3: Every beat after the first is driven as SEQ (2'b11). On a cycle where hready is low, haddr and htrans keep their values.
- R4: In an incrementing burst (burst codes 001 INCR, 011 INCR4, 101 INCR8, 111 INCR16), each beat address equals the previous beat address plus 2^size bytes.
- R5: In a wrapping burst (010 WRAP4, 100 WRAP8, 110 WRAP16), addresses step by 2^size and wrap inside an aligned block of beats x 2^size bytes. For example, a WRAP4 burst of 4-byte words from 0x34 gives 0x34, 0x38, 0x3C, 0x30. Wrapping bursts are never refused for the 1 KB rule.
- R6: A fixed-length burst issues exactly 4, 8 or 16 beats as encoded. After its last beat is taken, htrans returns to IDLE and done is 1 for exactly that one cycle.
- R7: A SINGLE request (burst 000) issues exactly one NONSEQ beat, then returns to IDLE with done.
- R8: An undefined-length INCR burst ends with the beat taken when stop is high. A stop seen during a wait state is remembered and ends the burst at the next taken beat.
- R9: An undefined-length INCR burst ends on its own after the beat whose successor would begin a new 1 KB block, so no beat crosses the boundary.
- R10: A fixed-length incrementing request whose bytes run past a 1 KB boundary is refused: err is 1 for one cycle and htrans stays IDLE. A burst that ends exactly on the boundary is accepted.
- R11: A request with size greater than MAX_SIZE (default 2, a 32-bit bus) is refused with err and no transfer.
- R12: hsize and hburst stay constant for every beat of a burst. A start while a burst is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a new burst (taken only while idle) |
| addr | input | ADDR_W | Start address of the request |
| burst | input | 3 | Requested burst type code |
| size | input | 3 | Requested transfer size, log2 of bytes |
| hready | input | 1 | Bus ready; a beat is taken on an edge where it is high |
| stop | input | 1 | End request for an undefined-length burst |
| haddr | output | ADDR_W | Address of the current beat |
| htrans | output | 2 | Transfer type: 00 IDLE, 10 NONSEQ, 11 SEQ |
| hburst | output | 3 | Burst type of the burst in progress |
| hsize | output | 3 | Transfer size of the burst in progress |
| done | output | 1 | One-cycle pulse when the bus returns to IDLE after a burst |
| err | output | 1 | One-cycle pulse when a request is refused |

## Verification
The bound checker checks several rules on every cycle. It checks that addresses and transfer types hold through wait states, and that hsize and hburst do not change during a burst. It checks the step between incrementing beats, that wrapping beats stay inside their aligned block, and that no incrementing SEQ beat lands on a 1 KB boundary. It also checks that done and err are single-cycle pulses seen only while idle. Only the directed scenarios show the rest: the exact beat count for each code, the wrap example, when a stop ends an undefined-length burst, the refuse-or-accept edge at the 1 KB boundary, and that a start during a burst is ignored.

// File: rtl/burst_pkg.sv
// Package: shared transfer-type encoding, burst codes and derived widths
// for the burst address generator. Assumes a 3-bit burst code and a
// 3-bit log2 size code.
package burst_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] BT_SINGLE = 3'b000;
    localparam logic [2:0] BT_INCR   = 3'b001;

    // Beat counter wide enough for 16 beats.
    localparam int BEAT_W = 5;
    // Largest span: 16 beats x 128 bytes = 2048, held in 12 bits.
    localparam int SPAN_W = 12;

endpackage

// File: rtl/burst_decode.sv
// Module: burst_decode
// Turns a burst request into its beat count, its wrap span mask and its
// refusal conditions. It is purely combinational.
// Assumes BOUNDARY is a power of two and ADDR_W >= log2(BOUNDARY).
module burst_decode
    import burst_pkg::*;
#(
    parameter int BOUNDARY = 1024,
    parameter int MAX_SIZE = 2,
    localparam int BND_W   = $clog2(BOUNDARY),
    localparam int EXT_W   = ((BND_W > SPAN_W) ? BND_W : SPAN_W) + 1
) (
    input  logic [BND_W-1:0]  addr_lo,
    input  logic [2:0]        burst,
    input  logic [2:0]        size,
    output logic [BEAT_W-1:0] beats,
    output logic [SPAN_W-1:0] wrap_mask,
    output logic              is_wrap,
    output logic              is_undef,
    output logic              refuse
);

    logic [2:0]        beat_log;
    logic [SPAN_W-1:0] span;
    logic              fixed_incr;
    logic              crosses;
    logic              size_bad;

    // Purpose: map the burst code to a beat count and its log2.
    always_comb begin
        unique case (burst[2:1])
            2'b00:   beat_log = 3'd0;
            2'b01:   beat_log = 3'd2;
            2'b10:   beat_log = 3'd3;
            default: beat_log = 3'd4;
        endcase
        beats = (burst == BT_INCR) ? '0 : (BEAT_W'(1) << beat_log);
    end

    // Purpose: classify the burst and compute its span and mask.
    always_comb begin
        is_wrap    = (burst[0] == 1'b0) && (burst != BT_SINGLE);
        is_undef   = (burst == BT_INCR);
        fixed_incr = burst[0] && !is_undef;
        span       = (SPAN_W'(1) << size) << beat_log;
        wrap_mask  = span - SPAN_W'(1);
    end

    // Purpose: refusal tests for the 1 KB rule and the bus width.
    always_comb begin
        crosses  = (EXT_W'(addr_lo) + EXT_W'(span)) > EXT_W'(BOUNDARY);
        size_bad = (int'(size) > MAX_SIZE);
        refuse   = size_bad || (fixed_incr && crosses);
    end

endmodule

// File: rtl/burst_step.sv
// Module: burst_step
// Works out the address of the next beat from the current one. The
// WRAP_EN parameter selects whether the wrap datapath is built.
// It also flags when the incremented address starts a new boundary block.
// Assumes ADDR_W >= SPAN_W and ADDR_W >= log2(BOUNDARY).
module burst_step
    import burst_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BOUNDARY = 1024,
    parameter bit WRAP_EN  = 1'b1,
    localparam int BND_W   = $clog2(BOUNDARY)
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [2:0]        size,
    input  logic              is_wrap,
    input  logic [SPAN_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] nxt,
    output logic              at_edge
);

    logic [ADDR_W-1:0] inc;

    // Purpose: linear increment by the transfer size.
    always_comb begin
        inc     = cur + (ADDR_W'(1) << size);
        at_edge = (inc[BND_W-1:0] == '0);
    end

    generate
        if (WRAP_EN) begin : g_wrap
            logic [ADDR_W-1:0] mask_ext;
            // Purpose: keep the high bits and wrap the low bits inside the span.
            always_comb begin
                mask_ext = ADDR_W'(wrap_mask);
                nxt      = is_wrap ? ((cur & ~mask_ext) | (inc & mask_ext)) : inc;
            end
        end else begin : g_nowrap
            logic unused_wrap;
            // Purpose: no wrap support; every burst is linear.
            always_comb begin
                unused_wrap = is_wrap ^ (^wrap_mask);
                nxt         = inc;
            end
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Master-side burst address sequencer. It takes a request while idle,
// refuses it or drives NONSEQ, then SEQ beats, and moves on only when
// hready is high. It returns to IDLE with a done pulse after the last beat.
// Assumes start, addr, burst and size are valid in the cycle start is high.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BOUNDARY = 1024,
    parameter int MAX_SIZE = 2,
    localparam int BND_W   = $clog2(BOUNDARY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        burst,
    input  logic [2:0]        size,
    input  logic              hready,
    input  logic              stop,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic [2:0]        hburst,
    output logic [2:0]        hsize,
    output logic              done,
    output logic              err
);

    // Request decode.
    logic [BEAT_W-1:0] req_beats;
    logic [SPAN_W-1:0] req_mask;
    logic              req_wrap;
    logic              req_undef;
    logic              req_refuse;

    // Burst state.
    trans_e            htrans_q;
    logic [ADDR_W-1:0] haddr_q;
    logic [2:0]        hburst_q;
    logic [2:0]        hsize_q;
    logic [BEAT_W-1:0] beats_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [SPAN_W-1:0] mask_q;
    logic              wrap_q;
    logic              undef_q;
    logic              stop_pend_q;
    logic              done_q;
    logic              err_q;

    // Next-beat datapath.
    logic [ADDR_W-1:0] nxt_addr;
    logic              nxt_edge;
    logic              active;
    logic              last_beat;

    burst_decode #(
        .BOUNDARY (BOUNDARY),
        .MAX_SIZE (MAX_SIZE)
    ) u_decode (
        .addr_lo   (addr[BND_W-1:0]),
        .burst     (burst),
        .size      (size),
        .beats     (req_beats),
        .wrap_mask (req_mask),
        .is_wrap   (req_wrap),
        .is_undef  (req_undef),
        .refuse    (req_refuse)
    );

    burst_step #(
        .ADDR_W   (ADDR_W),
        .BOUNDARY (BOUNDARY),
        .WRAP_EN  (1'b1)
    ) u_step (
        .cur       (haddr_q),
        .size      (hsize_q),
        .is_wrap   (wrap_q),
        .wrap_mask (mask_q),
        .nxt       (nxt_addr),
        .at_edge   (nxt_edge)
    );

    // Purpose: decide whether the beat now on the bus is the final one.
    always_comb begin
        active    = (htrans_q != TR_IDLE);
        last_beat = undef_q ? (stop || stop_pend_q || nxt_edge)
                            : (cnt_q == beats_q);
    end

    // Purpose: burst sequencing, request capture and the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htrans_q    <= TR_IDLE;
            haddr_q     <= '0;
            hburst_q    <= '0;
            hsize_q     <= '0;
            beats_q     <= '0;
            cnt_q       <= '0;
            mask_q      <= '0;
            wrap_q      <= 1'b0;
            undef_q     <= 1'b0;
            stop_pend_q <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (!active) begin
                if (start) begin
                    if (req_refuse) begin
                        err_q <= 1'b1;
                    end else begin
                        htrans_q    <= TR_NONSEQ;
                        haddr_q     <= addr;
                        hburst_q    <= burst;
                        hsize_q     <= size;
                        beats_q     <= req_beats;
                        mask_q      <= req_mask;
                        wrap_q      <= req_wrap;
                        undef_q     <= req_undef;
                        cnt_q       <= BEAT_W'(1);
                        stop_pend_q <= 1'b0;
                    end
                end
            end else begin
                if (undef_q && stop) begin
                    stop_pend_q <= 1'b1;
                end
                if (hready) begin
                    if (last_beat) begin
                        htrans_q    <= TR_IDLE;
                        done_q      <= 1'b1;
                        stop_pend_q <= 1'b0;
                    end else begin
                        htrans_q <= TR_SEQ;
                        haddr_q  <= nxt_addr;
                        cnt_q    <= cnt_q + BEAT_W'(1);
                    end
                end
            end
        end
    end

    assign haddr  = haddr_q;
    assign htrans = htrans_q;
    assign hburst = hburst_q;
    assign hsize  = hsize_q;
    assign done   = done_q;
    assign err    = err_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Protocol checker bound to burst_addr_gen. It looks only at the ports.
// Assumes the default boundary of 1 KB (BND_W address bits).
module burst_addr_gen_chk #(
    parameter int ADDR_W   = 32,
    parameter int BOUNDARY = 1024,
    localparam int BND_W   = $clog2(BOUNDARY)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hready,
    input logic [ADDR_W-1:0] haddr,
    input logic [1:0]        htrans,
    input logic [2:0]        hburst,
    input logic [2:0]        hsize,
    input logic              done,
    input logic              err
);

    logic [ADDR_W-1:0] span_mask;
    logic [2:0]        beat_log;

    // Purpose: recompute the wrap block mask from the driven controls.
    always_comb begin
        case (hburst[2:1])
            2'b01:   beat_log = 3'd2;
            2'b10:   beat_log = 3'd3;
            2'b11:   beat_log = 3'd4;
            default: beat_log = 3'd0;
        endcase
        span_mask = ((ADDR_W'(1) << hsize) << beat_log) - ADDR_W'(1);
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (htrans == 2'b00 && !done && !err));

    p_nonseq_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b10) |-> ($past(htrans) == 2'b00 || !$past(hready)));

    p_hold_on_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00 && !hready) |=> ($stable(haddr) && $stable(htrans)));

    p_incr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11 && hburst[0] && $past(hready))
        |-> (haddr == $past(haddr) + (ADDR_W'(1) << hsize)));

    p_wrap_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11 && !hburst[0])
        |-> ((haddr & ~span_mask) == ($past(haddr) & ~span_mask)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (htrans == 2'b00 ##1 !done));

    p_no_1kb_cross_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11 && hburst[0]) |-> (haddr[BND_W-1:0] != '0));

    p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (htrans == 2'b00 ##1 !err));

    p_ctrl_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11) |-> ($stable(hsize) && $stable(hburst)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W   (ADDR_W),
    .BOUNDARY (BOUNDARY)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hready (hready),
    .haddr  (haddr),
    .htrans (htrans),
    .hburst (hburst),
    .hsize  (hsize),
    .done   (done),
    .err    (err)
);

// File: tb/tb_burst_addr_gen.sv
// Directed bench for burst_addr_gen: one task per scenario.
module tb_burst_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] addr;
    logic [2:0]    burst;
    logic [2:0]    size;
    logic          hready;
    logic          stop;
    logic [AW-1:0] haddr;
    logic [1:0]    htrans;
    logic [2:0]    hburst;
    logic [2:0]    hsize;
    logic          done;
    logic          err;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .burst(burst), .size(size), .hready(hready), .stop(stop),
        .haddr(haddr), .htrans(htrans), .hburst(hburst), .hsize(hsize),
        .done(done), .err(err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] model_addr(logic [AW-1:0] a0, logic [2:0] b,
                                                 logic [2:0] s, int i);
        int bytes = 1 << s;
        int nb;
        logic [AW-1:0] span;
        logic [AW-1:0] base;
        case (b)
            3'b010, 3'b011: nb = 4;
            3'b100, 3'b101: nb = 8;
            3'b110, 3'b111: nb = 16;
            default:        nb = 1;
        endcase
        if (b[0] == 1'b0 && b != 3'b000) begin
            span = AW'(nb * bytes);
            base = a0 - (a0 % span);
            return base + (((a0 % span) + AW'(i * bytes)) % span);
        end
        return a0 + AW'(i * bytes);
    endfunction

    task automatic request(logic [AW-1:0] a, logic [2:0] b, logic [2:0] s);
        addr = a; burst = b; size = s; start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    // Runs a full burst at hready high and checks every beat and the end.
    task automatic run_fixed(string req, logic [AW-1:0] a, logic [2:0] b,
                             logic [2:0] s, int nb);
        hready = 1'b1;
        request(a, b, s);
        for (int i = 0; i < nb; i++) begin
            if (i > 0) tick();
            chk(req, "htrans", AW'(htrans), (i == 0) ? AW'(2) : AW'(3));
            chk(req, "haddr", haddr, model_addr(a, b, s, i));
            chk("R12", "hsize", AW'(hsize), AW'(s));
            chk("R12", "hburst", AW'(hburst), AW'(b));
        end
        tick();
        chk("R6", "htrans after last", AW'(htrans), AW'(0));
        chk("R6", "done", AW'(done), AW'(1));
        tick();
        chk("R6", "done one cycle", AW'(done), AW'(0));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; addr = '0; burst = '0; size = '0;
        hready = 1'b1; stop = 1'b0;
        tick(); tick();
        chk("R1", "htrans in reset", AW'(htrans), AW'(0));
        rst_n = 1'b1;
        tick();
        chk("R1", "htrans", AW'(htrans), AW'(0));
        chk("R1", "done", AW'(done), AW'(0));
        chk("R1", "err", AW'(err), AW'(0));
    endtask

    task automatic t_wrap();
        run_fixed("R5", 32'h34, 3'b010, 3'd2, 4);
        run_fixed("R5", 32'h0E, 3'b100, 3'd1, 8);
        run_fixed("R5", 32'h3FC, 3'b010, 3'd2, 4);
        run_fixed("R5", 32'h1237, 3'b110, 3'd0, 16);
    endtask

    task automatic t_incr();
        run_fixed("R4", 32'h1000, 3'b011, 3'd2, 4);
        run_fixed("R4", 32'h2002, 3'b101, 3'd1, 8);
        run_fixed("R4", 32'h3F0, 3'b111, 3'd0, 16);
        run_fixed("R7", 32'h55, 3'b000, 3'd0, 1);
    endtask

    task automatic t_stall();
        hready = 1'b1;
        request(32'h200, 3'b011, 3'd2);
        chk("R2", "htrans", AW'(htrans), AW'(2));
        chk("R2", "haddr", haddr, 32'h200);
        hready = 1'b0;
        tick();
        chk("R3", "hold htrans", AW'(htrans), AW'(2));
        chk("R3", "hold haddr", haddr, 32'h200);
        hready = 1'b1;
        tick();
        chk("R3", "seq", AW'(htrans), AW'(3));
        chk("R4", "haddr", haddr, 32'h204);
        hready = 1'b0;
        addr = 32'h8000; burst = 3'b000; start = 1'b1;
        tick(); tick();
        start = 1'b0;
        chk("R12", "start ignored haddr", haddr, 32'h204);
        chk("R12", "start ignored hburst", AW'(hburst), AW'(3));
        hready = 1'b1;
        tick();
        chk("R4", "haddr", haddr, 32'h208);
        tick();
        chk("R4", "haddr", haddr, 32'h20C);
        tick();
        chk("R6", "idle", AW'(htrans), AW'(0));
        chk("R6", "done", AW'(done), AW'(1));
        tick();
    endtask

    task automatic t_undef();
        hready = 1'b1;
        request(32'h100, 3'b001, 3'd2);
        chk("R8", "nonseq", AW'(htrans), AW'(2));
        tick();
        chk("R8", "haddr", haddr, 32'h104);
        tick();
        chk("R8", "haddr", haddr, 32'h108);
        stop = 1'b1;
        tick();
        stop = 1'b0;
        chk("R8", "stop ends", AW'(htrans), AW'(0));
        chk("R8", "done", AW'(done), AW'(1));
        tick();
        request(32'h180, 3'b001, 3'd2);
        hready = 1'b0; stop = 1'b1;
        tick();
        chk("R8", "wait hold", haddr, 32'h180);
        stop = 1'b0; hready = 1'b1;
        tick();
        chk("R8", "pending stop ends", AW'(htrans), AW'(0));
        chk("R8", "done", AW'(done), AW'(1));
        tick();
        request(32'h3F8, 3'b001, 3'd2);
        tick();
        chk("R9", "haddr", haddr, 32'h3FC);
        chk("R9", "seq", AW'(htrans), AW'(3));
        tick();
        chk("R9", "ends at 1KB", AW'(htrans), AW'(0));
        chk("R9", "done", AW'(done), AW'(1));
        tick();
    endtask

    task automatic t_refuse();
        hready = 1'b1;
        request(32'h3F8, 3'b011, 3'd2);
        chk("R10", "err", AW'(err), AW'(1));
        chk("R10", "idle", AW'(htrans), AW'(0));
        tick();
        chk("R10", "err one cycle", AW'(err), AW'(0));
        chk("R10", "still idle", AW'(htrans), AW'(0));
        run_fixed("R10", 32'h3F0, 3'b011, 3'd2, 4);
        request(32'h40, 3'b000, 3'd3);
        chk("R11", "err", AW'(err), AW'(1));
        chk("R11", "idle", AW'(htrans), AW'(0));
        tick();
        chk("R11", "still idle", AW'(htrans), AW'(0));
    endtask

    initial begin
        t_reset();
        t_wrap();
        t_incr();
        t_stall();
        t_undef();
        t_refuse();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule